// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block resolves the frequency configuration of a clock generator. While the power-on reset sequence runs, a set of shared pads is treated as inputs. Their levels are sampled into a small strap register. When the reset sequence reports completion, the pads are handed over to the clock output drivers and the strap register stops sampling.

A register bit picks the source of the active 3-bit frequency-select code: either the latched straps or a code held in the control bank. The code is decoded into an operating mode for the output dividers and gating. The block also produces the spread enables for the processor PLL and the serial-link PLL, each of which can be forced on from an asynchronous pin. Finally it produces the effective PLL multiplier and divider words. These come either from programmed register words or from a default table indexed by the active code.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: While `rst_n` is low, `pad_oe` is 0, `strap_val` is 0, and both spread enables reflect only their register bits (the synchronized pin contributes 0).
- R2: While `pad_oe` is 0, `strap_val` loads `pad_in` on every rising clock edge. On the first edge where `por_done` is 1, `strap_val` takes its last sample and `pad_oe` becomes 1.
- R3: Once `pad_oe` is 1, it and `strap_val` hold their values until the next reset, whatever `pad_in` and `por_done` do.
- R4: With `reg_fs_src` = 0, `fs_code` equals `strap_val[2:0]`. With `reg_fs_src` = 1, `fs_code` equals `reg_fs_code[2:0]`. `reg_fs_code[3]` has no effect on any output.
- R5: `fs_mode` is 2'b01 (all outputs tri-stated) for code 000, 2'b10 (reference bypass) for code 001, and 2'b00 (normal synthesis) for every other code.
- R6: `cpu_ss_en` is `reg_cpu_ss` OR the synchronized `spread_pin`, and `src_ss_en` is `reg_src_ss` OR the same synchronized pin. A pin change reaches the enables on the second rising edge after it.
- R7: With `reg_mn_en` = 1, each PLL's programmed 16-bit word is split as follows: bits 15:14 give N[9:8], bits 13:8 give M[5:0], and bits 7:0 give N[7:0]. The processor PLL uses `reg_cpu_mn` and the serial-link PLL uses `reg_src_mn`.
- R8: With `reg_mn_en` = 0, M is 12 for both PLLs. The serial-link PLL's N is 774. The processor PLL's N depends on the active code: 000, 001 and 100 give 383; 010 gives 696; 011 gives 852; 101 gives 514; 110 gives 644; 111 gives 774.
- R9: The default processor N/M follows the active `fs_code`, whichever source selected it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| por_done | input | 1 | Power-on sequence complete, synchronous to clk |
| pad_in | input | 5 | Raw levels on the shared strap pads |
| spread_pin | input | 1 | Asynchronous active-high spread force |
| reg_fs_src | input | 1 | 0: strap code, 1: register code |
| reg_fs_code | input | 4 | Register frequency-select code, bit 3 unused |
| reg_cpu_ss | input | 1 | Spread request for the processor PLL |
| reg_src_ss | input | 1 | Spread request for the serial-link PLL |
| reg_mn_en | input | 1 | Use programmed N/M words |
| reg_cpu_mn | input | 16 | Programmed processor PLL N/M word |
| reg_src_mn | input | 16 | Programmed serial-link PLL N/M word |
| pad_oe | output | 1 | 1 once the shared pads drive clocks |
| strap_val | output | 5 | Latched strap levels |
| fs_code | output | 3 | Resolved frequency-select code |
| fs_mode | output | 2 | 00 normal, 01 tri-state, 10 bypass |
| cpu_ss_en | output | 1 | Processor PLL spread enable |
| src_ss_en | output | 1 | Serial-link PLL spread enable |
| cpu_n | output | 10 | Effective processor PLL N |
| cpu_m | output | 6 | Effective processor PLL M |
| src_n | output | 10 | Effective serial-link PLL N |
| src_m | output | 6 | Effective serial-link PLL M |

## Verification
A corrupted strap register or a wrong output-enable flag is visible at the ports on the very next edge. `strap_val` moves after the pads were handed over, or `pad_oe` falls without a reset, and both flow straight into `fs_code`, `fs_mode` and the default N/M in the same cycle. A fault in the pin synchronizer only shows after two edges, as a spread enable that follows the pin too early, too late or not at all. A swapped field in the N/M split or a wrong table entry shows only when the matching source and code are selected, so the scenarios step through both sources and several codes.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int FS_W  = 3;
  localparam int N_W   = 10;
  localparam int M_W   = 6;
  localparam int MN_W  = N_W + M_W;
  localparam int N_HI  = N_W - 8;

  typedef enum logic [1:0] {
    FS_MODE_NORMAL   = 2'b00,
    FS_MODE_TRISTATE = 2'b01,
    FS_MODE_BYPASS   = 2'b10
  } fs_mode_e;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } mn_t;

  localparam logic [M_W-1:0] M_DEFAULT = 6'd12;
  localparam mn_t SRC_MN_DEFAULT = '{n: 10'd774, m: M_DEFAULT};

  function automatic fs_mode_e fs_mode_of(input logic [FS_W-1:0] code);
    case (code)
      3'b000:  return FS_MODE_TRISTATE;
      3'b001:  return FS_MODE_BYPASS;
      default: return FS_MODE_NORMAL;
    endcase
  endfunction

  function automatic mn_t cpu_mn_default(input logic [FS_W-1:0] code);
    mn_t r;
    r.m = M_DEFAULT;
    case (code)
      3'b010:  r.n = 10'd696;
      3'b011:  r.n = 10'd852;
      3'b101:  r.n = 10'd514;
      3'b110:  r.n = 10'd644;
      3'b111:  r.n = 10'd774;
      default: r.n = 10'd383;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         por_done,
  input  logic [W-1:0] pad_in,
  output logic         pad_oe,
  output logic [W-1:0] strap_q
);
  logic         oe_q, oe_d;
  logic [W-1:0] strap_r, strap_d;
  logic         sample_en;

  always_comb begin
    sample_en = ~oe_q;
    oe_d      = oe_q | por_done;
    strap_d   = sample_en ? pad_in : strap_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      strap_r <= '0;
    end else begin
      oe_q    <= oe_d;
      strap_r <= strap_d;
    end
  end

  assign pad_oe  = oe_q;
  assign strap_q = strap_r;
endmodule

// File: rtl/fsel_sync.sv
module fsel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q, sr_d;

  always_comb begin
    sr_d[0] = d;
    for (int i = 1; i < STAGES; i++) sr_d[i] = sr_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/fsel_mn_select.sv
module fsel_mn_select
  import fsel_pkg::*;
(
  input  logic            prog_en,
  input  logic [MN_W-1:0] prog_word,
  input  mn_t             dflt,
  output mn_t             eff
);
  localparam int M_LO = 8;

  always_comb begin
    if (prog_en) begin
      eff.n = {prog_word[MN_W-1 -: N_HI], prog_word[7:0]};
      eff.m = prog_word[M_LO +: M_W];
    end else begin
      eff = dflt;
    end
  end
endmodule

// File: rtl/fsel_strap_ctrl.sv
module fsel_strap_ctrl
  import fsel_pkg::*;
#(
  parameter int STRAP_W     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_done,
  input  logic [STRAP_W-1:0] pad_in,
  input  logic               spread_pin,
  input  logic               reg_fs_src,
  input  logic [3:0]         reg_fs_code,
  input  logic               reg_cpu_ss,
  input  logic               reg_src_ss,
  input  logic               reg_mn_en,
  input  logic [15:0]        reg_cpu_mn,
  input  logic [15:0]        reg_src_mn,
  output logic               pad_oe,
  output logic [STRAP_W-1:0] strap_val,
  output logic [2:0]         fs_code,
  output logic [1:0]         fs_mode,
  output logic               cpu_ss_en,
  output logic               src_ss_en,
  output logic [9:0]         cpu_n,
  output logic [5:0]         cpu_m,
  output logic [9:0]         src_n,
  output logic [5:0]         src_m
);
  localparam int NUM_PLL = 2;
  localparam int PLL_CPU = 0;
  localparam int PLL_SRC = 1;

  logic            pin_sync;
  logic [FS_W-1:0] code_sel;
  mn_t             dflt   [NUM_PLL];
  mn_t             eff    [NUM_PLL];
  logic [MN_W-1:0] words  [NUM_PLL];

  fsel_strap_latch #(.W(STRAP_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_done (por_done),
    .pad_in   (pad_in),
    .pad_oe   (pad_oe),
    .strap_q  (strap_val)
  );

  fsel_sync #(.STAGES(SYNC_STAGES)) u_spread_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (spread_pin),
    .q     (pin_sync)
  );

  always_comb begin
    code_sel = reg_fs_src ? reg_fs_code[FS_W-1:0] : strap_val[FS_W-1:0];
    dflt[PLL_CPU]  = cpu_mn_default(code_sel);
    dflt[PLL_SRC]  = SRC_MN_DEFAULT;
    words[PLL_CPU] = reg_cpu_mn;
    words[PLL_SRC] = reg_src_mn;
  end

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    fsel_mn_select u_mn (
      .prog_en   (reg_mn_en),
      .prog_word (words[g]),
      .dflt      (dflt[g]),
      .eff       (eff[g])
    );
  end

  assign fs_code   = code_sel;
  assign fs_mode   = fs_mode_of(code_sel);
  assign cpu_ss_en = reg_cpu_ss | pin_sync;
  assign src_ss_en = reg_src_ss | pin_sync;
  assign cpu_n     = eff[PLL_CPU].n;
  assign cpu_m     = eff[PLL_CPU].m;
  assign src_n     = eff[PLL_SRC].n;
  assign src_m     = eff[PLL_SRC].m;
endmodule

// File: rtl/fsel_strap_ctrl_chk.sv
module fsel_strap_ctrl_chk #(
  parameter int STRAP_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               por_done,
  input logic               spread_pin,
  input logic               reg_fs_src,
  input logic               reg_mn_en,
  input logic [15:0]        reg_cpu_mn,
  input logic               pad_oe,
  input logic [STRAP_W-1:0] strap_val,
  input logic [2:0]         fs_code,
  input logic [1:0]         fs_mode,
  input logic               cpu_ss_en,
  input logic               src_ss_en,
  input logic [9:0]         cpu_n,
  input logic [5:0]         cpu_m
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  a_r2_oe_after_por: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_oe) |-> $past(por_done));

  a_r3_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |=> pad_oe);

  a_r3_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |=> $stable(strap_val));

  a_r4_strap_source: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_fs_src |-> fs_code == strap_val[2:0]);

  a_r5_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_code == 3'b000) |-> fs_mode == 2'b01);

  a_r6_pin_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && $past(spread_pin, 2)) |-> (cpu_ss_en && src_ss_en));

  a_r7_prog_split: assert property (@(posedge clk) disable iff (!rst_n)
    reg_mn_en |-> (cpu_n == {reg_cpu_mn[15:14], reg_cpu_mn[7:0]} &&
                   cpu_m == reg_cpu_mn[13:8]));
endmodule

bind fsel_strap_ctrl fsel_strap_ctrl_chk #(.STRAP_W(STRAP_W)) u_chk (.*);

// File: tb/fsel_strap_ctrl_bench.sv
module fsel_strap_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        por_done;
  logic [4:0]  pad_in;
  logic        spread_pin;
  logic        reg_fs_src;
  logic [3:0]  reg_fs_code;
  logic        reg_cpu_ss, reg_src_ss, reg_mn_en;
  logic [15:0] reg_cpu_mn, reg_src_mn;
  logic        pad_oe;
  logic [4:0]  strap_val;
  logic [2:0]  fs_code;
  logic [1:0]  fs_mode;
  logic        cpu_ss_en, src_ss_en;
  logic [9:0]  cpu_n, src_n;
  logic [5:0]  cpu_m, src_m;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fsel_strap_ctrl u_fsel_strap_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 strap", strap_val, 0);
    chk("R1 cpu_ss", cpu_ss_en, 0);
    chk("R1 src_ss", src_ss_en, 0);
  endtask

  task automatic t_capture;
    pad_in = 5'h0A; step(1);
    chk("R2 sample", strap_val, 5'h0A);
    chk("R2 oe low", pad_oe, 0);
    pad_in = 5'h15; por_done = 1'b1; step(1);
    chk("R2 last sample", strap_val, 5'h15);
    chk("R2 oe high", pad_oe, 1);
  endtask

  task automatic t_hold;
    pad_in = 5'h03; por_done = 1'b0; step(3);
    chk("R3 strap held", strap_val, 5'h15);
    chk("R3 oe held", pad_oe, 1);
  endtask

  task automatic t_fs;
    reg_fs_src = 1'b0; reg_fs_code = 4'b0111; step(1);
    chk("R4 strap code", fs_code, 3'b101);
    chk("R5 normal", fs_mode, 2'b00);
    chk("R9 dflt n strap", cpu_n, 10'd514);
    chk("R8 dflt m", cpu_m, 6'd12);
    reg_fs_src = 1'b1; reg_fs_code = 4'b1000; step(1);
    chk("R4 reg code bit3 ignored", fs_code, 3'b000);
    chk("R5 tristate", fs_mode, 2'b01);
    chk("R8 n code0", cpu_n, 10'd383);
    reg_fs_code = 4'b0001; step(1);
    chk("R5 bypass", fs_mode, 2'b10);
    reg_fs_code = 4'b0111; step(1);
    chk("R9 dflt n reg", cpu_n, 10'd774);
    reg_fs_code = 4'b1011; step(1);
    chk("R8 n code3", cpu_n, 10'd852);
    chk("R5 normal code3", fs_mode, 2'b00);
    reg_fs_code = 4'b0010; step(1);
    chk("R8 n code2", cpu_n, 10'd696);
    reg_fs_code = 4'b0110; step(1);
    chk("R8 n code6", cpu_n, 10'd644);
  endtask

  task automatic t_spread;
    spread_pin = 1'b1; step(1);
    chk("R6 one edge", cpu_ss_en, 0);
    step(1);
    chk("R6 cpu forced", cpu_ss_en, 1);
    chk("R6 src forced", src_ss_en, 1);
    spread_pin = 1'b0; reg_cpu_ss = 1'b1; step(3);
    chk("R6 cpu reg", cpu_ss_en, 1);
    chk("R6 src off", src_ss_en, 0);
    reg_cpu_ss = 1'b0; reg_src_ss = 1'b1; step(1);
    chk("R6 cpu off", cpu_ss_en, 0);
    chk("R6 src reg", src_ss_en, 1);
    reg_src_ss = 1'b0;
  endtask

  task automatic t_mn;
    reg_mn_en = 1'b1; reg_cpu_mn = 16'hC5AB; reg_src_mn = 16'h4210; step(1);
    chk("R7 cpu n", cpu_n, 10'h3AB);
    chk("R7 cpu m", cpu_m, 6'h05);
    chk("R7 src n", src_n, 10'h110);
    chk("R7 src m", src_m, 6'h02);
    reg_mn_en = 1'b0; step(1);
    chk("R8 src n", src_n, 10'd774);
    chk("R8 src m", src_m, 6'd12);
  endtask

  task automatic t_rereset;
    rst_n = 1'b0; step(1);
    chk("R1 oe after reset", pad_oe, 0);
    chk("R1 strap after reset", strap_val, 0);
    rst_n = 1'b1; pad_in = 5'h1C; step(1);
    chk("R2 resample", strap_val, 5'h1C);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; por_done = 1'b0; pad_in = 5'h1F; spread_pin = 1'b0;
    reg_fs_src = 1'b0; reg_fs_code = 4'b0; reg_cpu_ss = 1'b0; reg_src_ss = 1'b0;
    reg_mn_en = 1'b0; reg_cpu_mn = 16'h0; reg_src_mn = 16'h0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    t_capture();
    t_hold();
    t_fs();
    t_spread();
    t_mn();
    t_rereset();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule